// File: doc/BRIEF.md
# Strap-Pin Boot Source Selector

This block decides, once per reset, where a processor should load its first code from. It reads two strap pins: a primary select and a secondary select. It does not read them at once after reset. For a fixed number of clock cycles it first asks the pad logic to pull both pins low. This lets an unconnected pin settle to a known low level. At the end of that window it captures both levels and derives a boot source from them: internal flash, the SPI loader or the UART loader.

Flash is the only source that can fail and hand over to a second source. When the flash loader reports a failure, the block moves to SPI or to UART. The captured secondary pin picks which one. When UART is the active source, the block issues a periodic request to send the fixed sync character. The period equals one 10-bit character time at the configured baud rate, so the host sees an unbroken run of that character while it prepares its loader commands. The UART transmitter and the loaders sit outside this block.

Top module: `boot_strap_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it, the pull-down request is high, and the sample strobe, the done flag and the sync request are low. The source code reads 0.
- R2: After reset is released, the pull-down request stays high for exactly PD_CYCLES clock cycles. It falls in the same cycle as the sample strobe, which is high for that one cycle only.
- R3: The pin levels are captured at the clock edge that ends the window. Pin changes after that edge have no effect on any output until the next reset.
- R4: Both pins low selects UART (source code 2), and the done flag rises together with the sample strobe.
- R5: Primary pin low with secondary pin high selects SPI (source code 1), and the done flag rises together with the sample strobe.
- R6: Primary pin high selects flash (source code 0), and the done flag stays low while the flash attempt is in progress.
- R7: A boot-fail pulse while flash is active moves the source one cycle later. It goes to SPI (code 1) if the captured secondary pin was high and to UART (code 2) if it was low, and the done flag rises in that same cycle.
- R8: A boot-fail pulse during the pull-down window, or while SPI or UART is the active source, changes no output.
- R9: While UART is active, the sync request pulses in the first UART cycle and then every SYNC_PERIOD cycles. It is never high under any other source, and the sync byte output carries 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pri | input | 1 | Primary strap pin level (high requests flash first) |
| strap_sec | input | 1 | Secondary strap pin level (selects SPI vs UART) |
| boot_fail | input | 1 | One-cycle failure report from the active loader |
| strap_pd_en | output | 1 | Pull-down enable for both strap pads during the window |
| sample_vld | output | 1 | One-cycle strobe when the pins are captured |
| boot_src | output | 2 | Active source: 0 flash, 1 SPI, 2 UART |
| boot_done | output | 1 | High once the source can no longer change |
| sync_req | output | 1 | Strobe requesting one sync character |
| sync_byte | output | 8 | Sync character value (0x55) |

## Verification
The bench resets the block once for each of the four pin combinations and compares every output on every cycle with a behavioural model.

- The two flash combinations are each given a failure pulse. This separates the SPI fallback from the UART fallback, which depend only on the captured secondary pin.
- The UART combinations run long enough to see several sync strobes, which shows that the pacing period is right.
- Failure pulses sent inside the window and after SPI or UART is chosen, and pin flips made after sampling, show the inputs that must be ignored.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

   typedef enum logic [1:0] {
      SRC_FLASH = 2'd0,
      SRC_SPI   = 2'd1,
      SRC_UART  = 2'd2
   } boot_src_e;

   localparam logic [7:0] SYNC_CHAR = 8'h55;

endpackage

// File: rtl/boot_strap_window.sv
module boot_strap_window #(
   parameter int PD_CYCLES = 300
) (
   input  logic clk,
   input  logic rst_n,
   output logic pd_en,
   output logic cap_now,
   output logic sample_vld
);

   localparam int CW = $clog2(PD_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(PD_CYCLES - 1);

   if (PD_CYCLES < 1) begin : g_bad_window
      $error("PD_CYCLES must be at least 1");
   end

   logic          waiting_q;
   logic [CW-1:0] cnt_q;

   assign pd_en   = waiting_q;
   assign cap_now = waiting_q && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting_q  <= 1'b1;
         cnt_q      <= '0;
         sample_vld <= 1'b0;
      end else begin
         sample_vld <= cap_now;
         if (cap_now)
            waiting_q <= 1'b0;
         else if (waiting_q)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the pull-down is released exactly when the capture strobe appears
   p_pd_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_en) |-> sample_vld);

   // R2: the sample strobe lasts one cycle
   p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> !sample_vld);

endmodule

// File: rtl/boot_src_fsm.sv
module boot_src_fsm
   import boot_strap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cap_now,
   input  logic      pri,
   input  logic      sec,
   input  logic      boot_fail,
   output boot_src_e src,
   output logic      done,
   output logic      decided
);

   boot_src_e src_q;
   logic      sec_q;
   logic      done_q;
   logic      dec_q;

   assign src     = src_q;
   assign done    = done_q;
   assign decided = dec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_FLASH;
         sec_q  <= 1'b0;
         done_q <= 1'b0;
         dec_q  <= 1'b0;
      end else if (cap_now) begin
         dec_q <= 1'b1;
         sec_q <= sec;
         if (pri) begin
            src_q  <= SRC_FLASH;
            done_q <= 1'b0;
         end else begin
            src_q  <= sec ? SRC_SPI : SRC_UART;
            done_q <= 1'b1;
         end
      end else if (dec_q && !done_q && boot_fail) begin
         src_q  <= sec_q ? SRC_SPI : SRC_UART;
         done_q <= 1'b1;
      end
   end

   // R7: a failure during flash finalises the source on the next cycle
   p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_q && !done_q && boot_fail) |=> (done_q && src_q != SRC_FLASH));

   // R8: once final, neither a failure nor anything else moves the source
   p_final_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (done_q && $stable(src_q)));

endmodule

// File: rtl/boot_sync_pacer.sv
module boot_sync_pacer #(
   parameter int PERIOD = 130200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uart_act,
   output logic sync_req
);

   localparam int TW = $clog2(PERIOD);
   localparam logic [TW-1:0] WRAP = TW'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("sync PERIOD must be at least 2");
   end

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (!uart_act)
         tmr_q <= '0;
      else
         tmr_q <= (tmr_q == WRAP) ? '0 : tmr_q + 1'b1;
   end

   assign sync_req = uart_act && (tmr_q == '0);

   // R9: the request never appears without the UART source
   p_sync_uart_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |-> uart_act);

   // R9: requests are spaced, never on consecutive cycles
   p_sync_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> !sync_req);

endmodule

// File: rtl/boot_strap_sel.sv
module boot_strap_sel
   import boot_strap_pkg::*;
#(
   parameter int PD_CYCLES = 300,
   parameter int CLK_HZ    = 125_000_000,
   parameter int BAUD      = 9600,
   parameter int CHAR_BITS = 10,
   parameter bit SYNC_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_pri,
   input  logic       strap_sec,
   input  logic       boot_fail,
   output logic       strap_pd_en,
   output logic       sample_vld,
   output logic [1:0] boot_src,
   output logic       boot_done,
   output logic       sync_req,
   output logic [7:0] sync_byte
);

   localparam int SYNC_PERIOD = (CLK_HZ / BAUD) * CHAR_BITS;

   if (BAUD < 1 || CHAR_BITS < 1) begin : g_bad_rate
      $error("BAUD and CHAR_BITS must be positive");
   end

   logic      cap_now;
   logic      decided;
   boot_src_e src;

   boot_strap_window #(.PD_CYCLES(PD_CYCLES)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_en     (strap_pd_en),
      .cap_now   (cap_now),
      .sample_vld(sample_vld)
   );

   boot_src_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_now  (cap_now),
      .pri      (strap_pri),
      .sec      (strap_sec),
      .boot_fail(boot_fail),
      .src      (src),
      .done     (boot_done),
      .decided  (decided)
   );

   assign boot_src  = src;
   assign sync_byte = SYNC_CHAR;

   if (SYNC_EN) begin : g_sync
      boot_sync_pacer #(.PERIOD(SYNC_PERIOD)) u_pacer (
         .clk     (clk),
         .rst_n   (rst_n),
         .uart_act(decided && src == SRC_UART),
         .sync_req(sync_req)
      );
   end else begin : g_nosync
      assign sync_req = 1'b0;
   end

   // R1: nothing is final or strobed while the pads are still pulled down
   p_window_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      strap_pd_en |-> (!boot_done && !sample_vld && !sync_req));

   // R3: after the window the pull-down never returns
   p_pd_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_pd_en |=> !strap_pd_en);

endmodule

// File: tb/boot_strap_sel_tb.sv
module boot_strap_sel_tb_top;

   localparam int PD  = 300;
   localparam int PER = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_pri = 1'b0;
   logic       strap_sec = 1'b0;
   logic       boot_fail = 1'b0;
   logic       strap_pd_en, sample_vld, boot_done, sync_req;
   logic [1:0] boot_src;
   logic [7:0] sync_byte;

   int    n_chk = 0;
   int    n_err = 0;
   int    cycles = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   boot_strap_sel #(
      .PD_CYCLES(PD), .CLK_HZ(96000), .BAUD(9600), .CHAR_BITS(10), .SYNC_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_pri(strap_pri), .strap_sec(strap_sec),
      .boot_fail(boot_fail), .strap_pd_en(strap_pd_en), .sample_vld(sample_vld),
      .boot_src(boot_src), .boot_done(boot_done), .sync_req(sync_req),
      .sync_byte(sync_byte)
   );

   // behavioural reference model
   int m_left, m_src, m_tmr;
   bit m_wait, m_vld, m_done, m_dec, m_sec;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wait = 1; m_left = PD; m_vld = 0; m_src = 0;
         m_done = 0; m_dec = 0; m_sec = 0; m_tmr = 0;
      end else begin
         if (m_dec && m_src == 2) m_tmr = (m_tmr + 1) % PER;
         else m_tmr = 0;
         m_vld = 0;
         if (m_wait) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
               m_wait = 0; m_vld = 1; m_dec = 1; m_sec = strap_sec;
               if (strap_pri) begin m_src = 0; m_done = 0; end
               else begin m_src = strap_sec ? 1 : 2; m_done = 1; end
            end
         end else if (!m_done && boot_fail) begin
            m_src = m_sec ? 1 : 2;
            m_done = 1;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk("R2", "pd_en", strap_pd_en, m_wait);
         chk("R2", "sample_vld", sample_vld, m_vld);
         chk(tag, "boot_src", boot_src, m_src);
         chk(tag, "boot_done", boot_done, m_done);
         chk("R9", "sync_req", sync_req, (m_dec && m_src == 2 && m_tmr == 0) ? 1 : 0);
      end
      if (cycles > 100000) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_fail();
      boot_fail = 1'b1; @(negedge clk); boot_fail = 1'b0;
   endtask

   task automatic do_reset(input logic p, input logic s);
      rst_n = 1'b0; strap_pri = p; strap_sec = s; boot_fail = 1'b0;
      cyc(3);
      // R1: reset state
      chk("R1", "pd_en in reset", strap_pd_en, 1);
      chk("R1", "vld in reset", sample_vld, 0);
      chk("R1", "done in reset", boot_done, 0);
      chk("R1", "src in reset", boot_src, 0);
      chk("R1", "sync in reset", sync_req, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      // R4 / R3 / R8 / R9: both low -> UART, later pin flips and fails ignored
      tag = "R4";
      do_reset(1'b0, 1'b0);
      cyc(PD);
      chk("R4", "src after window", boot_src, 2);
      chk("R9", "sync byte", sync_byte, 8'h55);
      tag = "R3"; strap_pri = 1'b1; strap_sec = 1'b1; cyc(20);
      tag = "R8"; pulse_fail(); cyc(250);
      chk("R8", "src after ignored fail", boot_src, 2);

      // R5: SPI, fail ignored
      tag = "R5";
      do_reset(1'b0, 1'b1);
      cyc(PD);
      chk("R5", "src after window", boot_src, 1);
      tag = "R8"; pulse_fail(); cyc(30);

      // R6 / R7: flash then fallback to SPI
      tag = "R6";
      do_reset(1'b1, 1'b1);
      cyc(PD + 40);
      chk("R6", "flash done low", boot_done, 0);
      tag = "R7"; strap_sec = 1'b0; pulse_fail(); cyc(5);
      chk("R7", "fallback spi", boot_src, 1);
      chk("R7", "done after fallback", boot_done, 1);

      // R8 / R7: fail in window ignored, flash then fallback to UART
      tag = "R8";
      do_reset(1'b1, 1'b0);
      cyc(100); pulse_fail(); cyc(PD - 101);
      chk("R6", "flash selected", boot_src, 0);
      tag = "R7"; cyc(20); pulse_fail(); cyc(230);
      chk("R7", "fallback uart", boot_src, 2);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule